// File: doc/BRIEF.md
# Big-Endian Word Load/Store Unit

This block sits between a 32-bit register datapath and a small byte-addressed data store. A request carries a 32-bit base value, a signed 16-bit displacement and, for a write, a 32-bit data word. The unit adds the sign-extended displacement to the base to form the effective byte address. It rejects any address whose two low bits are not zero. Aligned requests move one whole word.

Storage is four byte banks. Bank k holds every byte whose address has low bits equal to k. A word is laid out most-significant byte first: the byte at the word address carries bits 31:24 and the byte at address+3 carries bits 7:0. The store size is a power-of-two parameter, and address bits above that size do not select anything.

Requests use a valid/ready port. The unit takes a request only when no response is waiting. The response appears on the next clock and stays until the consumer takes it.

Top module: `be_lsu`

## Requirements
- R1: The effective address is `req_base_i` plus `req_offset_i` sign-extended to 32 bits. A negative displacement reaches addresses below the base.
- R2: A request whose effective address has bits 1:0 not equal to 00 completes with `rsp_err_o`=1 and `rsp_rdata_o`=0.
- R3: A misaligned store leaves every stored word unchanged.
- R4: A load returns the word most recently stored at the same effective address. Words at neighbouring aligned addresses are held independently.
- R5: `rsp_valid_o` rises on the clock edge after a request is accepted. While `rsp_ready_i` is low, `rsp_valid_o`, `rsp_rdata_o` and `rsp_err_o` hold their values.
- R6: `req_ready_o` is low whenever `rsp_valid_o` is high. It is high again on the clock edge after the response is taken.
- R7: Effective-address bits at or above log2(MEM_BYTES) are ignored, so addresses that differ only in those bits reach the same word.
- R8: After reset, `rsp_valid_o`=0, `rsp_err_o`=0 and `req_ready_o`=1.
- R9: An aligned store completes with `rsp_err_o`=0 and `rsp_rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit can take a request |
| req_store_i | input | 1 | 1 = store word, 0 = load word |
| req_base_i | input | 32 | Base register value |
| req_offset_i | input | 16 | Signed byte displacement |
| req_wdata_i | input | 32 | Store data |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Consumer takes the response |
| rsp_rdata_o | output | 32 | Load data; zero for stores and errors |
| rsp_err_o | output | 1 | Misaligned access |

## Verification
The round trip stores distinct byte patterns and loads them back through a different base/displacement split, including a negative displacement. A wrong sign extension or a bank/lane swap that is not mirrored on the read side breaks this check. Misaligned requests with low bits 01 and 10 are followed by an aligned load, which shows both the error response and an untouched store. A store through a base with high bits set, read back through the plain low address, shows the aliasing. A response held back for several cycles shows that valid, data and ready stay stable.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;
  localparam int unsigned WORD_BYTES = 4;
  typedef logic [31:0] word_t;
  typedef logic [7:0]  byte_t;
  typedef logic [15:0] disp_t;
endpackage

// File: rtl/be_lsu_agen.sv
module be_lsu_agen
  import be_lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  word_t             base_i,
  input  disp_t             disp_i,
  output logic [ADDR_W-3:0] word_idx_o,
  output logic              misaligned_o
);
  word_t eff;
  word_t unused_eff;

  assign eff          = base_i + {{16{disp_i[15]}}, disp_i};
  assign word_idx_o   = eff[ADDR_W-1:2];
  assign misaligned_o = |eff[1:0];
  assign unused_eff   = eff;
endmodule

// File: rtl/be_lsu_bank.sv
module be_lsu_bank
  import be_lsu_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] idx_i,
  input  byte_t            wbyte_i,
  output byte_t            rbyte_o
);
  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wbyte_i;
    if (re_i) rbyte_o <= mem_q[idx_i];
  end
endmodule

// File: rtl/be_lsu.sv
module be_lsu
  import be_lsu_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_store_i,
  input  logic [31:0] req_base_i,
  input  logic [15:0] req_offset_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  input  logic        rsp_ready_i,
  output logic [31:0] rsp_rdata_o,
  output logic        rsp_err_o
);
  localparam int unsigned ADDR_W = $clog2(MEM_BYTES);
  localparam int unsigned DEPTH  = MEM_BYTES / WORD_BYTES;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             misaligned;
  logic             accept, do_wr, do_rd;
  logic             rsp_valid_q, rsp_err_q, rsp_load_q;
  word_t            rd_word;

  be_lsu_agen #(.ADDR_W(ADDR_W)) u_agen (
    .base_i       (req_base_i),
    .disp_i       (req_offset_i),
    .word_idx_o   (word_idx),
    .misaligned_o (misaligned)
  );

  assign req_ready_o = ~rsp_valid_q;
  assign accept      = req_valid_i & req_ready_o;
  assign do_wr       = accept & req_store_i & ~misaligned;
  assign do_rd       = accept & ~req_store_i & ~misaligned;

  // Bank k holds byte address offset k; offset 0 is the most significant byte
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_bank
    be_lsu_bank #(.DEPTH(DEPTH)) u_bank (
      .clk_i   (clk_i),
      .we_i    (do_wr),
      .re_i    (do_rd),
      .idx_i   (word_idx),
      .wbyte_i (req_wdata_i[31-8*k -: 8]),
      .rbyte_o (rd_word[31-8*k -: 8])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_load_q  <= 1'b0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_err_q   <= misaligned;
      rsp_load_q  <= do_rd;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_load_q ? rd_word : '0;
endmodule

// File: rtl/be_lsu_chk.sv
module be_lsu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        req_store_i,
  input logic [31:0] req_base_i,
  input logic [15:0] req_offset_i,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [31:0] rsp_rdata_o,
  input logic        rsp_err_o
);
  logic       acc;
  logic [1:0] low_sum;
  assign acc     = req_valid_i & req_ready_o;
  assign low_sum = req_base_i[1:0] + req_offset_i[1:0];

  // R6
  ready_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  // R5
  rsp_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);

  // R5
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_err_o)));

  // R5
  rsp_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(acc));

  // R2
  misalign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && low_sum != 2'b00) |=> (rsp_err_o && rsp_rdata_o == 32'h0));

  // R9
  store_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_store_i && low_sum == 2'b00) |=> (!rsp_err_o && rsp_rdata_o == 32'h0));
endmodule

bind be_lsu be_lsu_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_store_i  (req_store_i),
  .req_base_i   (req_base_i),
  .req_offset_i (req_offset_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_rdata_o  (rsp_rdata_o),
  .rsp_err_o    (rsp_err_o)
);

// File: tb/be_lsu_test.sv
module be_lsu_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] got_d;
  logic        got_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  be_lsu #(.MEM_BYTES(1024)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_store_i(req_store), .req_base_i(req_base),
    .req_offset_i(req_offset), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One transfer; response taken after 'hold' stalled cycles
  task automatic xfer(logic st, logic [31:0] base, logic [15:0] off,
                      logic [31:0] wd, int hold, output logic [31:0] d, output logic e);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_base = base; req_offset = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R5 valid after accept", {31'b0, rsp_valid}, 32'd1);
    check("R6 ready low while pending", {31'b0, req_ready}, 32'd0);
    d = rsp_rdata; e = rsp_err;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R5 valid held", {31'b0, rsp_valid}, 32'd1);
      check("R5 data held", rsp_rdata, d);
      check("R5 err held", {31'b0, rsp_err}, {31'b0, e});
      check("R6 ready held low", {31'b0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R6 ready back", {31'b0, req_ready}, 32'd1);
    check("R5 valid cleared", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check("R8 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R8 rsp_err", {31'b0, rsp_err}, 32'd0);
    check("R8 req_ready", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_roundtrip();
    xfer(1'b1, 32'h100, 16'd32, 32'hA1B2C3D4, 0, got_d, got_e);
    check("R9 store err", {31'b0, got_e}, 32'd0);
    check("R9 store data", got_d, 32'h0);
    xfer(1'b0, 32'h120, 16'd0, 32'h0, 0, got_d, got_e);
    check("R4 load after store", got_d, 32'hA1B2C3D4);
    check("R4 load err", {31'b0, got_e}, 32'd0);
  endtask

  task automatic t_negoff();
    xfer(1'b1, 32'h124, 16'd0, 32'h01020304, 0, got_d, got_e);
    xfer(1'b0, 32'h128, 16'hFFFC, 32'h0, 0, got_d, got_e);
    check("R1 negative offset", got_d, 32'h01020304);
    xfer(1'b0, 32'h124, 16'hFFFC, 32'h0, 0, got_d, got_e);
    check("R1 R4 neighbour word", got_d, 32'hA1B2C3D4);
  endtask

  task automatic t_misalign();
    xfer(1'b1, 32'h120, 16'd1, 32'hDEADBEEF, 0, got_d, got_e);
    check("R2 store err", {31'b0, got_e}, 32'd1);
    check("R2 store data zero", got_d, 32'h0);
    xfer(1'b1, 32'h11E, 16'd0, 32'hCAFEF00D, 0, got_d, got_e);
    check("R2 store err low 10", {31'b0, got_e}, 32'd1);
    xfer(1'b0, 32'h120, 16'd2, 32'h0, 0, got_d, got_e);
    check("R2 load err", {31'b0, got_e}, 32'd1);
    check("R2 load data zero", got_d, 32'h0);
    xfer(1'b0, 32'h120, 16'd0, 32'h0, 0, got_d, got_e);
    check("R3 memory unchanged 0x120", got_d, 32'hA1B2C3D4);
    xfer(1'b0, 32'h11C, 16'd0, 32'h0, 0, got_d, got_e);
    check("R3 neighbour unchanged 0x11C", got_d, 32'h0);
  endtask

  task automatic t_alias();
    xfer(1'b1, 32'h7000_0040, 16'd0, 32'h55AA33CC, 0, got_d, got_e);
    xfer(1'b0, 32'h40, 16'd0, 32'h0, 0, got_d, got_e);
    check("R7 high bits ignored", got_d, 32'h55AA33CC);
  endtask

  task automatic t_hold();
    xfer(1'b0, 32'h124, 16'd0, 32'h0, 3, got_d, got_e);
    check("R5 held load data", got_d, 32'h01020304);
  endtask

  initial begin
    // zero the word at 0x11C so R3 has a known neighbour value
    #(CLK_PERIOD*2);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    xfer(1'b1, 32'h11C, 16'd0, 32'h0, 0, got_d, got_e);
    t_roundtrip();
    t_negoff();
    t_misalign();
    t_alias();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*5000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule